// File: doc/BRIEF.md
# I2C Register-Pointer Target

This block is a byte-addressed I2C target. It lets an external bus controller read and write a small register file that sits beside it. The block runs on a system clock that is much faster than SCL. It passes SCL and SDA through a synchronizer, finds bus conditions with edge detection, and pulls SDA low only through an open-drain enable (`sda_oe` high means the line is driven low).

In a write transaction, the first data byte after the device address is a word address, and it loads an internal pointer. Each further byte produces a one-cycle write strobe to the register at the pointer, and the pointer then advances. A read transaction sends the register at the pointer, advances, and goes on while the controller acknowledges. A read therefore continues from wherever the last transaction left the pointer. A repeated START restarts address matching and keeps the pointer, so the usual pattern is: write the word address, issue a repeated START, then read.

The state machine has eight named states:

| State | Role |
|---|---|
| ST_IDLE | Waits for a START. |
| ST_ADDR | Shifts in the address byte. |
| ST_ADDR_ACK | Drives the acknowledge for the address byte. |
| ST_WR_BYTE | Receives a byte. |
| ST_WR_ACK | Drives the acknowledge for a received byte. |
| ST_RD_BYTE | Shifts out a byte. |
| ST_RD_ACK | Samples the controller's acknowledge. |
| ST_IGNORE | Stays released until the next START. |

The transitions are:

- From any state, START goes to ST_ADDR and STOP goes to ST_IDLE.
- ST_ADDR goes to ST_ADDR_ACK on a matching address and to ST_IGNORE otherwise.
- ST_ADDR_ACK goes to ST_WR_BYTE or ST_RD_BYTE, chosen by the direction bit.
- ST_WR_BYTE and ST_WR_ACK alternate.
- ST_RD_BYTE goes to ST_RD_ACK.
- ST_RD_ACK goes back to ST_RD_BYTE on ACK and to ST_IGNORE on NACK.

Top module: `i2c_regptr_target`

## Requirements
- R1: The target answers only the 7-bit address 1101000. The eighth bit gives the direction (0 = write to target, 1 = read from target). On a match, SDA is held low during the ninth clock. On any other address, no acknowledge is given and SDA stays released until the next START.
- R2: Every byte is transferred MSB first. Eight data clocks are followed by a ninth acknowledge clock.
- R3: In a write, the first byte after the address loads the pointer and produces no write strobe. A value of 19 or more loads 0.
- R4: Each later write byte produces exactly one cycle of `reg_we`, with `reg_waddr` equal to the pointer and `reg_wdata` equal to the byte. The pointer then advances by one.
- R5: The target acknowledges every byte it receives in a write, including the word address byte.
- R6: A read returns the register at the current pointer and advances the pointer after each byte sent. After a read, the pointer holds the index one past the last byte sent.
- R7: When the controller NACKs a read byte, the target releases SDA and drives nothing more until the next START.
- R8: A repeated START restarts address matching and leaves the pointer unchanged.
- R9: The pointer wraps from 18 to 0 on auto-increment, in both writes and reads.
- R10: The `sda_oe` output changes only while the synchronized SCL is low.
- R11: A STOP releases SDA and returns the target to idle.
- R12: The byte being sent is captured when its first bit is driven. Changes on `reg_rdata` during the byte do not alter the bits on the bus.
- R13: After reset, `sda_oe` and `reg_we` are low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when high |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_waddr | output | 5 | Register index for the write |
| reg_wdata | output | 8 | Byte to write |
| reg_raddr | output | 5 | Register index to read (the pointer) |
| reg_rdata | input | 8 | Combinational read data for `reg_raddr` |

## Verification
The checker watches four behaviours on every cycle:

- `sda_oe` moves only while SCL is low.
- Write strobes last a single cycle.
- Both register indices stay below 19.
- SDA is released after STOP and while the target is ignoring the bus.

Only the bench's bus scenarios can show the data-level behaviours:

- the word-address load and its clamp;
- the ordering of written and read bytes, with wrap-around;
- the pointer surviving a repeated START, and a read continuing from where the last transaction stopped;
- the refusal to acknowledge a foreign address;
- the stability of a byte while `reg_rdata` is disturbed in the middle of that byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_BITS = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizes SCL/SDA and decodes edges and bus conditions.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= scl_i;
                    sda_ff <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[STAGES-2:0], scl_i};
                    sda_ff <= {sda_ff[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_lvl = scl_ff[STAGES-1];
    assign sda_lvl = sda_ff[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_lvl;
            sda_q <= sda_lvl;
        end
    end

    assign scl_rise  = scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl & scl_q;
    assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/i2c_ptr_ctr.sv
// Register pointer: loads with clamp, increments with wrap.
module i2c_ptr_ctr #(
    parameter int NUM_REGS = 19,
    localparam int AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [7:0]    load_val,
    input  logic          inc,
    output logic [AW-1:0] ptr
);

    localparam logic [AW-1:0] LAST = AW'(NUM_REGS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            if (int'(load_val) < NUM_REGS) begin
                ptr <= load_val[AW-1:0];
            end else begin
                ptr <= '0;
            end
        end else if (inc) begin
            ptr <= (ptr == LAST) ? '0 : ptr + AW'(1);
        end
    end

endmodule

// File: rtl/i2c_regptr_target.sv
module i2c_regptr_target
    import i2c_tgt_pkg::*;
#(
    parameter int          NUM_REGS    = 19,
    parameter logic [6:0]  DEV_ADDR    = 7'b1101000,
    parameter int          SYNC_STAGES = 2,
    localparam int         AW          = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    output logic          reg_we,
    output logic [AW-1:0] reg_waddr,
    output logic [7:0]    reg_wdata,
    output logic [AW-1:0] reg_raddr,
    input  logic [7:0]    reg_rdata
);

    localparam logic [3:0] CNT_FULL = 4'(BYTE_BITS);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    tgt_state_e state_q, state_d;
    logic [3:0]    bit_cnt;
    logic [7:0]    rx_sr;
    logic [7:0]    tx_sr;
    logic          first_q;
    logic          mack_q;
    logic [AW-1:0] ptr;

    logic bus_ok, byte_end, addr_hit;
    logic ptr_load, wr_fire, ptr_inc, tx_load;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_ptr_ctr #(.NUM_REGS(NUM_REGS)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (rx_sr),
        .inc      (ptr_inc),
        .ptr      (ptr)
    );

    assign reg_raddr = ptr;
    assign bus_ok    = ~start_det & ~stop_det;
    assign byte_end  = scl_fall & (bit_cnt == CNT_FULL);
    assign addr_hit  = (rx_sr[7:1] == DEV_ADDR);

    // Control strobes for the pointer and the register side
    always_comb begin
        ptr_load = bus_ok && (state_q == ST_WR_BYTE) && byte_end && first_q;
        wr_fire  = bus_ok && (state_q == ST_WR_BYTE) && byte_end && !first_q;
        ptr_inc  = wr_fire || (bus_ok && (state_q == ST_RD_BYTE) && byte_end);
        tx_load  = bus_ok && scl_fall &&
                   (((state_q == ST_ADDR_ACK) && rx_sr[0]) ||
                    ((state_q == ST_RD_ACK) && mack_q));
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (byte_end) state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) state_d = rx_sr[0] ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (byte_end) state_d = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_d = ST_WR_BYTE;
                ST_RD_BYTE:  if (byte_end) state_d = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) state_d = mack_q ? ST_RD_BYTE : ST_IGNORE;
                ST_IGNORE:   state_d = ST_IGNORE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sr     <= '0;
            tx_sr     <= '0;
            first_q   <= 1'b0;
            mack_q    <= 1'b0;
            sda_oe    <= 1'b0;
            reg_we    <= 1'b0;
            reg_waddr <= '0;
            reg_wdata <= '0;
        end else begin
            reg_we <= wr_fire;
            if (wr_fire) begin
                reg_waddr <= ptr;
                reg_wdata <= rx_sr;
            end

            if (!bus_ok) begin
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_WR_BYTE: begin
                        if (scl_rise) begin
                            rx_sr   <= {rx_sr[6:0], sda_lvl};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                        if (byte_end) begin
                            bit_cnt <= '0;
                            sda_oe  <= (state_q == ST_ADDR) ? addr_hit : 1'b1;
                            if (state_q == ST_WR_BYTE) begin
                                first_q <= 1'b0;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            first_q <= 1'b1;
                            bit_cnt <= '0;
                            if (tx_load) begin
                                tx_sr  <= reg_rdata;
                                sda_oe <= ~reg_rdata[7];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                        if (scl_fall) begin
                            if (bit_cnt == CNT_FULL) begin
                                bit_cnt <= '0;
                                sda_oe  <= 1'b0;
                            end else begin
                                tx_sr  <= {tx_sr[6:0], 1'b0};
                                sda_oe <= ~tx_sr[6];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_lvl;
                        end
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (tx_load) begin
                                tx_sr  <= reg_rdata;
                                sda_oe <= ~reg_rdata[7];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_regptr_target_chk.sv
module i2c_regptr_target_chk
    import i2c_tgt_pkg::*;
#(
    parameter int NUM_REGS = 19,
    localparam int AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_lvl,
    input logic          stop_det,
    input logic          sda_oe,
    input logic          reg_we,
    input logic [AW-1:0] reg_waddr,
    input logic [AW-1:0] reg_raddr,
    input tgt_state_e    state_q
);

    a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_lvl));

    a_r4_we_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    a_r9_waddr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (int'(reg_waddr) < NUM_REGS));

    a_r9_raddr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(reg_raddr) < NUM_REGS);

    a_r11_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    a_r7_ignore_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |-> !sda_oe);

endmodule

bind i2c_regptr_target i2c_regptr_target_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_lvl),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .reg_we    (reg_we),
    .reg_waddr (reg_waddr),
    .reg_raddr (reg_raddr),
    .state_q   (state_q)
);

// File: tb/i2c_regptr_target_tb.sv
`timescale 1ns/1ps
module i2c_regptr_target_tb;

    localparam int NREG = 19;
    localparam int QT   = 8;
    localparam logic [6:0] ADDR = 7'b1101000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_bus;
    logic sda_oe, reg_we;
    logic [4:0] reg_waddr, reg_raddr;
    logic [7:0] reg_wdata, reg_rdata;
    logic garble = 1'b0;

    logic [7:0] regs [NREG];
    logic [7:0] exp_regs [NREG];
    int exp_ptr = 0;
    logic [4:0] log_a [256];
    logic [7:0] log_d [256];
    int log_n = 0;
    logic [7:0] wbuf [8];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;
    always_comb reg_rdata = garble ? ~regs[reg_raddr] : regs[reg_raddr];

    i2c_regptr_target u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe(sda_oe), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] init_val(int i);
        return 8'((i * 37 + 11) & 8'hff);
    endfunction

    function automatic int nxt(int p);
        return (p == NREG - 1) ? 0 : p + 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= init_val(i);
        end else if (reg_we) begin
            regs[reg_waddr] <= reg_wdata;
            log_a[log_n[7:0]] <= reg_waddr;
            log_d[log_n[7:0]] <= reg_wdata;
            log_n <= log_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hq;
        repeat (QT) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; hq; scl_m = 1'b1; hq; hq;
        sda_m = 1'b0; hq; hq; scl_m = 1'b0; hq;
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; hq; scl_m = 1'b1; hq; hq;
        sda_m = 1'b1; hq; hq;
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; hq; scl_m = 1'b1; hq; hq; scl_m = 1'b0; hq;
    endtask

    task automatic recv_bit(output logic v);
        sda_m = 1'b1; hq; scl_m = 1'b1; hq; v = sda_bus; hq; scl_m = 1'b0; hq;
    endtask

    task automatic wr_byte(input logic [7:0] d, output logic nack);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(nack);
    endtask

    task automatic rd_byte(input bit ack, input bit garb, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            if (garb && i == 6) garble = 1'b1;
            recv_bit(b);
            d[i] = b;
        end
        garble = 1'b0;
        send_bit(!ack);
    endtask

    // Word-address write followed by n data bytes from wbuf
    task automatic xfer_write(input logic [7:0] p, input int n);
        logic nk;
        int base, q;
        base = log_n;
        bus_start;
        wr_byte({ADDR, 1'b0}, nk); chk(nk == 1'b0, "R1 addr ack", nk, 0);
        wr_byte(p, nk);            chk(nk == 1'b0, "R5 ptr ack", nk, 0);
        exp_ptr = (int'(p) < NREG) ? int'(p) : 0;
        for (int k = 0; k < n; k++) begin
            wr_byte(wbuf[k], nk);
            chk(nk == 1'b0, "R5 data ack", nk, 0);
        end
        bus_stop;
        chk(sda_oe == 1'b0, "R11 stop release", sda_oe, 0);
        chk(log_n - base == n, "R3 strobe count", log_n - base, n);
        q = exp_ptr;
        for (int k = 0; k < n && k < log_n - base; k++) begin
            chk(int'(log_a[8'(base + k)]) == q, "R4 write addr", log_a[8'(base + k)], q);
            chk(log_d[8'(base + k)] == wbuf[k], "R4 write data", log_d[8'(base + k)], wbuf[k]);
            exp_regs[q] = wbuf[k];
            q = nxt(q);
        end
        exp_ptr = q;
    endtask

    // Read n bytes from the current pointer; optional leading START
    task automatic xfer_read(input int n, input bit garb_first);
        logic nk;
        logic [7:0] d;
        bus_start;
        wr_byte({ADDR, 1'b1}, nk); chk(nk == 1'b0, "R1 read addr ack", nk, 0);
        for (int k = 0; k < n; k++) begin
            rd_byte(k < n - 1, garb_first && k == 0, d);
            chk(d == exp_regs[exp_ptr], garb_first ? "R12 latched byte" : "R6 read data",
                d, exp_regs[exp_ptr]);
            exp_ptr = nxt(exp_ptr);
        end
        chk(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);
        recv_bit(nk);
        chk(nk == 1'b1, "R7 line high after nack", nk, 1);
        bus_stop;
        chk(sda_oe == 1'b0, "R11 stop release", sda_oe, 0);
    endtask

    initial begin
        logic nk;
        logic [7:0] d;
        int len;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NREG; i++) exp_regs[i] = init_val(i);
        repeat (5) @(negedge clk);
        chk(sda_oe == 1'b0, "R13 reset sda_oe", sda_oe, 0);
        chk(reg_we == 1'b0, "R13 reset reg_we", reg_we, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R13 / R6: read with no prior write starts at register 0
        xfer_read(2, 0);

        // R1: foreign address is not acknowledged and causes no write
        begin
            int base;
            base = log_n;
            bus_start;
            wr_byte(8'hA0, nk); chk(nk == 1'b1, "R1 foreign addr nack", nk, 1);
            wr_byte(8'h00, nk); chk(nk == 1'b1, "R1 ignored byte nack", nk, 1);
            wr_byte(8'h55, nk); chk(nk == 1'b1, "R1 ignored byte nack", nk, 1);
            bus_stop;
            chk(log_n == base, "R1 no strobe on mismatch", log_n - base, 0);
        end

        // R2 / R4: MSB-first patterns written then read back
        wbuf[0] = 8'h80; wbuf[1] = 8'h01; wbuf[2] = 8'hA5;
        xfer_write(8'd5, 3);
        exp_ptr = 5;
        bus_start;
        wr_byte({ADDR, 1'b0}, nk); wr_byte(8'd5, nk);
        bus_stop;
        xfer_read(3, 0);

        // R8 / R9: repeated START keeps pointer; read wraps 18 -> 0
        bus_start;
        wr_byte({ADDR, 1'b0}, nk); chk(nk == 1'b0, "R8 addr ack", nk, 0);
        wr_byte(8'd16, nk);        chk(nk == 1'b0, "R5 ptr ack", nk, 0);
        exp_ptr = 16;
        bus_start;
        wr_byte({ADDR, 1'b1}, nk); chk(nk == 1'b0, "R8 restart addr ack", nk, 0);
        for (int k = 0; k < 5; k++) begin
            rd_byte(k < 4, 0, d);
            chk(d == exp_regs[exp_ptr], "R9 R8 wrap read", d, exp_regs[exp_ptr]);
            exp_ptr = nxt(exp_ptr);
        end
        bus_stop;

        // R6: read continues from where the last read stopped (pointer 2)
        xfer_read(1, 0);

        // R3: out-of-range word address loads 0
        wbuf[0] = 8'h3C;
        xfer_write(8'd25, 1);

        // R9: write wraps 18 -> 0
        wbuf[0] = 8'hE1; wbuf[1] = 8'h7E;
        xfer_write(8'd18, 2);

        // R12: reg_rdata disturbed mid-byte
        exp_ptr = 18;
        bus_start;
        wr_byte({ADDR, 1'b0}, nk); wr_byte(8'd18, nk);
        bus_stop;
        xfer_read(2, 1);

        // Random traffic
        for (int it = 0; it < 12; it++) begin
            len = 1 + int'($urandom % 4);
            for (int k = 0; k < len; k++) wbuf[k] = 8'($urandom);
            d = 8'($urandom % 22);
            xfer_write(d, len);
            exp_ptr = (int'(d) < NREG) ? int'(d) : 0;
            bus_start;
            wr_byte({ADDR, 1'b0}, nk); wr_byte(d, nk);
            bus_stop;
            xfer_read(len, (it % 3) == 0);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule